// File: doc/BRIEF.md
# Class D Switching Clock and PWM Generator

This block derives the carrier clock for a two-channel class D output stage from the system clock. A 3-bit select chooses one of eight division ratios. The smallest ratio is one and a half, so the divider uses both edges of the system clock. The carrier clock then drives a pulse-width modulator for each channel. The high time of each modulator follows a signed sample word, and each channel drives a complementary pair of pins for a bridge-tied load.

A 2-bit enable field turns each channel on or off. A channel that is switched on starts at the next modulation period boundary. A channel that is switched off drops both of its pins low on the next clock. The carrier must not change while any channel is running. A new divide select is therefore held off until both channels are off and have stopped. Each modulation period spans 2^SMP_W carrier periods, which is 64 with the default sample width of 6 bits.

Top module: `cdpwm_clkgen`

## Requirements
- R1: The divide select gives these carrier periods, in system clocks: code 001 gives 2, 010 gives 3, 011 gives 4, 100 gives 6, 101 gives 8, 110 gives 12 and 111 gives 16. Each of these ratios has a 50% high time.
- R2: Code 000 gives a carrier period of 1.5 system clocks. The carrier is high for one half-cycle of the system clock in each period.
- R3: After a synchronous active-high reset, the applied ratio is divide-by-16. With the enable field at 00, all four pins are low.
- R4: While any enable bit is set, or any channel is still running, a change on the divide select has no effect on the carrier. Once both channels are off, the carrier takes up the pending select.
- R5: Enable bit 0 controls the left channel and bit 1 controls the right channel (00 none, 01 left, 10 right, 11 both). A channel whose bit is clear has both pins low from the next clock edge onward.
- R6: The sample is two's complement. A running channel drives its positive pin high for the first (sample + 2^(SMP_W-1)) carrier periods of each modulation period of 2^SMP_W carrier periods. A zero sample therefore gives a 50% duty cycle, and the most negative sample keeps the positive pin low.
- R7: Each channel takes its sample only at a modulation period boundary. A sample change in the middle of a period alters the pulse only from the following period onward.
- R8: A channel whose enable bit is set starts driving its pins only at the next modulation period boundary.
- R9: While a channel runs, its negative pin is the complement of its positive pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_sel | input | 3 | Carrier divide select code |
| chan_en | input | 2 | Channel enables, bit 0 left, bit 1 right |
| left_smp | input | SMP_W | Left sample, two's complement |
| right_smp | input | SMP_W | Right sample, two's complement |
| sw_clk | output | 1 | Divided carrier clock |
| left_p | output | 1 | Left positive pin |
| left_n | output | 1 | Left negative pin |
| right_p | output | 1 | Right positive pin |
| right_n | output | 1 | Right negative pin |

## Verification
The hardest condition to reach is the moment just after a modulation period boundary. The ports give no phase marker, yet the boundary is where late samples are taken and where a newly enabled channel first drives its pins. The stimulus enables one channel from the idle state and waits for its pins to leave the all-low state. That event marks cycle zero of a period. Changes to a sample and to the second channel's enable are then placed at known offsets inside that period, and the pins are checked just before and just after the next boundary.

// File: rtl/cdpwm_pkg.sv
package cdpwm_pkg;

    // Width of the carrier divide counter (largest span is 16)
    localparam int CNT_W = 5;
    localparam int CHANS = 2;

    typedef enum logic [2:0] {
        DIV_1P5 = 3'b000,
        DIV_2   = 3'b001,
        DIV_3   = 3'b010,
        DIV_4   = 3'b011,
        DIV_6   = 3'b100,
        DIV_8   = 3'b101,
        DIV_12  = 3'b110,
        DIV_16  = 3'b111
    } div_sel_e;

    // How the rising-edge and falling-edge registers are merged
    typedef enum logic [1:0] {
        MERGE_RISE = 2'b00,   // rising-edge counter alone
        MERGE_OR   = 2'b01,   // odd ratio, 50% high time
        MERGE_XOR  = 2'b10    // three half-cycles per carrier period
    } merge_e;

    typedef struct packed {
        logic [CNT_W-1:0] span;   // counter length in system clocks
        merge_e           merge;
    } div_cfg_t;

    typedef struct packed {
        logic p;
        logic n;
    } pin_pair_t;

    function automatic div_cfg_t div_decode(input div_sel_e s);
        div_cfg_t c;
        unique case (s)
            DIV_1P5: begin c.span = CNT_W'(3);  c.merge = MERGE_XOR;  end
            DIV_2:   begin c.span = CNT_W'(2);  c.merge = MERGE_RISE; end
            DIV_3:   begin c.span = CNT_W'(3);  c.merge = MERGE_OR;   end
            DIV_4:   begin c.span = CNT_W'(4);  c.merge = MERGE_RISE; end
            DIV_6:   begin c.span = CNT_W'(6);  c.merge = MERGE_RISE; end
            DIV_8:   begin c.span = CNT_W'(8);  c.merge = MERGE_RISE; end
            DIV_12:  begin c.span = CNT_W'(12); c.merge = MERGE_RISE; end
            default: begin c.span = CNT_W'(16); c.merge = MERGE_RISE; end
        endcase
        return c;
    endfunction

    // Two's complement sample to offset-binary duty code
    function automatic logic [15:0] to_offset(input logic [15:0] s, input int w);
        logic [15:0] r;
        r = s;
        r[w-1] = ~s[w-1];
        return r;
    endfunction

endpackage

// File: rtl/cdpwm_divider.sv
module cdpwm_divider
    import cdpwm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] div_sel,
    input  logic       lock,
    output logic       sw_clk,
    output logic       tick
);

    div_sel_e         sel_q;
    div_cfg_t         cfg;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic             rise_q;
    logic             rise_d;
    logic             fall_q;

    always_comb begin
        cfg     = div_decode(sel_q);
        cnt_nxt = (cnt_q >= cfg.span - CNT_W'(1)) ? '0 : cnt_q + CNT_W'(1);
        unique case (cfg.merge)
            MERGE_XOR: rise_d = (cnt_nxt != CNT_W'(2));
            MERGE_OR:  rise_d = (cnt_nxt == '0);
            default:   rise_d = (cnt_nxt < (cfg.span >> 1));
        endcase
    end

    // Rising-edge half: select register, counter, rising-edge output register
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= DIV_16;
            cnt_q  <= '0;
            rise_q <= 1'b0;
        end else begin
            if (!lock) begin
                sel_q <= div_sel_e'(div_sel);
            end
            cnt_q  <= cnt_nxt;
            rise_q <= rise_d;
        end
    end

    // Falling-edge half: supplies the half-cycle resolution
    always_ff @(negedge clk) begin
        if (rst) begin
            fall_q <= 1'b0;
        end else begin
            unique case (cfg.merge)
                MERGE_XOR: fall_q <= (cnt_q == '0);
                MERGE_OR:  fall_q <= rise_q;
                default:   fall_q <= 1'b0;
            endcase
        end
    end

    always_comb begin
        unique case (cfg.merge)
            MERGE_XOR: begin
                sw_clk = rise_q ^ fall_q;
                tick   = (cnt_q != CNT_W'(1));
            end
            MERGE_OR: begin
                sw_clk = rise_q | fall_q;
                tick   = (cnt_q == cfg.span - CNT_W'(1));
            end
            default: begin
                sw_clk = rise_q;
                tick   = (cnt_q == cfg.span - CNT_W'(1));
            end
        endcase
    end

    // R4
    sel_lock_chk: assert property (@(posedge clk) disable iff (rst)
        lock |=> $stable(sel_q))
        else $error("divide select changed while locked");

endmodule

// File: rtl/cdpwm_stepper.sv
module cdpwm_stepper #(
    parameter int STEP_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    output logic [STEP_W-1:0] step,
    output logic              boundary
);

    logic [STEP_W-1:0] step_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= '0;
        end else if (tick) begin
            step_q <= step_q + STEP_W'(1);
        end
    end

    assign step     = step_q;
    assign boundary = tick && (step_q == '1);

    // R6
    step_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(step_q))
        else $error("step advanced without a carrier tick");

endmodule

// File: rtl/cdpwm_chan.sv
module cdpwm_chan
    import cdpwm_pkg::*;
#(
    parameter int SMP_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             boundary,
    input  logic [SMP_W-1:0] step,
    input  logic [SMP_W-1:0] sample,
    output pin_pair_t        pins,
    output logic             run
);

    logic [SMP_W-1:0] duty_q;
    logic             run_q;
    logic             level;
    logic [15:0]      offs;

    assign offs = to_offset(16'(sample), SMP_W);

    always_ff @(posedge clk) begin
        if (rst) begin
            duty_q <= '0;
            run_q  <= 1'b0;
        end else begin
            if (boundary) begin
                duty_q <= offs[SMP_W-1:0];
            end
            if (!en) begin
                run_q <= 1'b0;
            end else if (boundary) begin
                run_q <= 1'b1;
            end
        end
    end

    assign level  = (step < duty_q);
    assign pins.p = run_q & level;
    assign pins.n = run_q & ~level;
    assign run    = run_q;

    // R5
    off_pins_low_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (pins == '0))
        else $error("disabled channel drives a pin");

    // R8
    start_on_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(run_q) |-> $past(boundary))
        else $error("channel started away from a period boundary");

    // R7
    duty_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !boundary |=> $stable(duty_q))
        else $error("duty changed inside a period");

endmodule

// File: rtl/cdpwm_clkgen.sv
module cdpwm_clkgen
    import cdpwm_pkg::*;
#(
    parameter int SMP_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       div_sel,
    input  logic [1:0]       chan_en,
    input  logic [SMP_W-1:0] left_smp,
    input  logic [SMP_W-1:0] right_smp,
    output logic             sw_clk,
    output logic             left_p,
    output logic             left_n,
    output logic             right_p,
    output logic             right_n
);

    logic                         tick;
    logic                         boundary;
    logic [SMP_W-1:0]             step;
    logic [CHANS-1:0]             run;
    logic                         lock;
    logic [CHANS-1:0][SMP_W-1:0]  smp;
    pin_pair_t [CHANS-1:0]        pins;

    assign smp[0] = left_smp;
    assign smp[1] = right_smp;
    assign lock   = (|chan_en) | (|run);

    cdpwm_divider u_div (
        .clk     (clk),
        .rst     (rst),
        .div_sel (div_sel),
        .lock    (lock),
        .sw_clk  (sw_clk),
        .tick    (tick)
    );

    cdpwm_stepper #(.STEP_W(SMP_W)) u_step (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .step     (step),
        .boundary (boundary)
    );

    for (genvar g = 0; g < CHANS; g++) begin : g_chan
        cdpwm_chan #(.SMP_W(SMP_W)) u_chan (
            .clk      (clk),
            .rst      (rst),
            .en       (chan_en[g]),
            .boundary (boundary),
            .step     (step),
            .sample   (smp[g]),
            .pins     (pins[g]),
            .run      (run[g])
        );
    end

    assign left_p  = pins[0].p;
    assign left_n  = pins[0].n;
    assign right_p = pins[1].p;
    assign right_n = pins[1].n;

endmodule

// File: tb/cdpwm_clkgen_bench.sv
module cdpwm_clkgen_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int SMP_W = 6;

    // {select code, expected period ns, expected high ns}
    localparam int VEC[8][3] = '{
        '{0, 15, 5},   '{1, 20, 10},  '{2, 30, 15},  '{3, 40, 20},
        '{4, 60, 30},  '{5, 80, 40},  '{6, 120, 60}, '{7, 160, 80}
    };

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic [2:0]              div_sel = 3'b111;
    logic [1:0]              chan_en = 2'b00;
    logic signed [SMP_W-1:0] left_smp = '0;
    logic signed [SMP_W-1:0] right_smp = '0;
    logic sw_clk, left_p, left_n, right_p, right_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cdpwm_clkgen #(.SMP_W(SMP_W)) u_cdpwm_clkgen (
        .clk(clk), .rst(rst), .div_sel(div_sel), .chan_en(chan_en),
        .left_smp(left_smp), .right_smp(right_smp), .sw_clk(sw_clk),
        .left_p(left_p), .left_n(left_n), .right_p(right_p), .right_n(right_n)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic measure(output int per, output int hi);
        realtime t1, t2, t3;
        @(posedge sw_clk); t1 = $realtime;
        @(negedge sw_clk); t2 = $realtime;
        @(posedge sw_clk); t3 = $realtime;
        per = $rtoi(t3 - t1 + 0.5);
        hi  = $rtoi(t2 - t1 + 0.5);
        #2;
    endtask

    task automatic count_high(input bit right, input int n, output int hp, output int same);
        hp = 0;
        same = 0;
        for (int i = 0; i < n; i++) begin
            if (right ? right_p : left_p) hp++;
            if ((right ? right_p : left_p) == (right ? right_n : left_n)) same++;
            cyc(1);
        end
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all): actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int per, hi, hp, same, k;

        // R3: reset state
        cyc(4);
        rst = 1'b0;
        cyc(2);
        check({left_p, left_n, right_p, right_n} == 4'b0000, "R3", "pins after reset",
              int'({left_p, left_n, right_p, right_n}), 0);
        measure(per, hi);
        check(per == 160, "R3", "reset carrier period ns", per, 160);
        check(hi == 80, "R3", "reset carrier high ns", hi, 80);

        // R1 / R2: divide table
        for (int v = 0; v < 8; v++) begin
            div_sel = 3'(VEC[v][0]);
            cyc(40);
            measure(per, hi);
            check(per == VEC[v][1], (v == 0) ? "R2" : "R1", "carrier period ns", per, VEC[v][1]);
            check(hi == VEC[v][2], (v == 0) ? "R2" : "R1", "carrier high ns", hi, VEC[v][2]);
        end

        // R4: select locked while a channel is enabled
        div_sel = 3'b001;
        cyc(40);
        chan_en = 2'b01;
        cyc(5);
        div_sel = 3'b000;
        cyc(40);
        measure(per, hi);
        check(per == 20, "R4", "period while locked ns", per, 20);
        chan_en = 2'b00;
        cyc(40);
        measure(per, hi);
        check(per == 15, "R4", "period after unlock ns", per, 15);
        div_sel = 3'b001;
        cyc(40);

        // R8 / R7: locate a period boundary from the right channel start
        left_smp  = -32;
        right_smp = 0;
        chan_en   = 2'b10;
        k = 0;
        while (!(right_p | right_n) && k < 400) begin
            cyc(1);
            k++;
        end
        check(k >= 1 && k <= 130, "R8", "cycles until right channel starts", k, 128);
        cyc(20);                   // offset 20
        right_smp = 31;
        cyc(10);                   // offset 30
        chan_en = 2'b11;
        cyc(50);                   // offset 80
        check(right_p == 1'b0, "R7", "right pin keeps old sample mid-period", int'(right_p), 0);
        check(right_n == 1'b1, "R9", "right negative pin is complement", int'(right_n), 1);
        cyc(20);                   // offset 100
        check({left_p, left_n} == 2'b00, "R8", "left idle before boundary",
              int'({left_p, left_n}), 0);
        cyc(30);                   // offset 130, next period
        check({left_p, left_n} == 2'b01, "R6", "most negative sample keeps positive pin low",
              int'({left_p, left_n}), 1);
        cyc(78);                   // offset 208
        check(right_p == 1'b1, "R7", "right pin uses new sample next period", int'(right_p), 1);

        // R6 / R9: duty windows at divide-by-2 (128 clocks per period)
        left_smp  = 0;
        right_smp = 10;
        cyc(260);
        count_high(1'b0, 128, hp, same);
        check(hp == 64, "R6", "left high clocks, zero sample", hp, 64);
        check(same == 0, "R9", "left pins equal", same, 0);
        count_high(1'b1, 128, hp, same);
        check(hp == 84, "R6", "right high clocks, sample 10", hp, 84);
        check(same == 0, "R9", "right pins equal", same, 0);

        left_smp  = 31;
        right_smp = -16;
        cyc(260);
        count_high(1'b0, 128, hp, same);
        check(hp == 126, "R6", "left high clocks, sample 31", hp, 126);
        count_high(1'b1, 128, hp, same);
        check(hp == 32, "R6", "right high clocks, sample -16", hp, 32);

        left_smp = -32;
        cyc(260);
        count_high(1'b0, 128, hp, same);
        check(hp == 0, "R6", "left high clocks, sample -32", hp, 0);

        // R5: per-channel disable
        chan_en = 2'b01;
        cyc(2);
        check({right_p, right_n} == 2'b00, "R5", "right pins after disable",
              int'({right_p, right_n}), 0);
        check((left_p | left_n) == 1'b1, "R5", "left still running", int'(left_p | left_n), 1);
        chan_en = 2'b00;
        cyc(2);
        check({left_p, left_n} == 2'b00, "R5", "left pins after disable",
              int'({left_p, left_n}), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule